// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per cycle, which hardware threads of a simultaneous-multithreading core may fetch and how many instructions each of them may fetch. It fills up to `SLOTS` grant slots. Each slot carries a thread id and a fetch count of at most `PER_MAX`. The counts of all slots together never exceed the total fetch width `FETCH_W`. A thread is a candidate only while its ready flag is high and its stall flag is low.

Candidates are ranked by a key chosen by the policy input. The key can be one of three per-thread counters: instructions pending in the front end, unresolved branches, or outstanding cache misses. In round-robin mode the key is zero for every thread. Ties are broken by distance from a rotating pointer that advances by one thread every cycle. The pending-instruction counter is kept inside the block from fetch and issue events. The branch counter and the miss counter are kept inside the block from increment and decrement events. All three counters saturate at both ends. The grants are registered, so they appear one cycle after the inputs they were computed from.

Top module: `fetch_sel_top`

## Requirements
- R1: While rst_ni is low, all slots are invalid with zero id and count, all counters are zero and the rotating pointer is zero.
- R2: A thread is granted only if its ready_i bit was 1 and its stall_i bit was 0 in the cycle the grant was computed from.
- R3: With policy_i = 1, threads with fewer pending front-end instructions rank first. The pending counter of thread t changes each cycle by +fetch_num_i[t] and -issue_num_i[t], applied together.
- R4: Every counter saturates. A result below zero becomes 0, and a result above 2^CNT_W-1 becomes 2^CNT_W-1.
- R5: With policy_i = 0, all keys are equal, so slot 0 goes to the first candidate at or after the pointer. The pointer is 0 at the first edge after reset, advances by one every cycle and wraps at N_THR.
- R6: Threads with equal keys are ordered by (t - ptr) mod N_THR, smallest first.
- R7: With policy_i = 2, the key is the unresolved-branch counter. That counter changes by +br_inc_i[t] and -br_dec_i[t] each cycle.
- R8: With policy_i = 3, the key is the cache-miss counter. That counter changes by +miss_inc_i[t] and -miss_dec_i[t] each cycle.
- R9: Slots are filled in rank order from slot 0. Each valid slot gets min(PER_MAX, remaining width). A slot is invalid, with zero id and count, once the candidates or the width run out. Valid slots hold distinct threads, and their counts sum to at most FETCH_W.
- R10: Grants are registered. An input change shows at the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Ranking key: 0 round-robin, 1 pending instructions, 2 branches, 3 misses |
| ready_i | input | N_THR | Per-thread ready flag |
| stall_i | input | N_THR | Per-thread stall flag |
| fetch_num_i | input | N_THR*EW | Per-thread instructions fetched this cycle |
| issue_num_i | input | N_THR*EW | Per-thread instructions issued this cycle |
| br_inc_i | input | N_THR | Per-thread branch entered the front end |
| br_dec_i | input | N_THR | Per-thread branch resolved |
| miss_inc_i | input | N_THR | Per-thread cache miss started |
| miss_dec_i | input | N_THR | Per-thread cache miss returned |
| slot_vld_o | output | SLOTS | Grant slot valid |
| slot_tid_o | output | SLOTS*TW | Granted thread id per slot |
| slot_num_o | output | SLOTS*NW | Granted fetch count per slot |

EW = clog2(FETCH_W+1), TW = clog2(N_THR), NW = clog2(PER_MAX+1).

## Verification
The bench builds the block with 8 threads, 3 slots, PER_MAX = 4, FETCH_W = 10 and 4-bit counters. With these values the width limit binds: the third slot gets 2 instructions instead of 4. Heavy event bursts reach both saturation limits within a few cycles. A behavioural model runs alongside the design in all four policies, with random ready and stall patterns. The tie phases use equal counters so that ranking falls back to the rotating pointer.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;
  typedef enum logic [1:0] {
    POL_RR   = 2'd0,
    POL_ICNT = 2'd1,
    POL_BR   = 2'd2,
    POL_MISS = 2'd3
  } fetch_pol_e;
endpackage

// File: rtl/fetch_sat_cnt.sv
module fetch_sat_cnt #(
  parameter int CNT_W  = 5,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] inc_i,
  input  logic [STEP_W-1:0] dec_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int SW = CNT_W + STEP_W + 2;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0]     cnt_q;
  logic signed [SW-1:0] sum;

  always_comb sum = $signed(SW'(cnt_q)) + $signed(SW'(inc_i)) - $signed(SW'(dec_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (sum < 0)                    cnt_q <= '0;
    else if (sum > $signed(SW'(CMAX)))   cnt_q <= CMAX;
    else                                 cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fetch_ranker.sv
module fetch_ranker #(
  parameter int N_THR   = 8,
  parameter int SLOTS   = 2,
  parameter int PER_MAX = 4,
  parameter int FETCH_W = 8,
  parameter int CNT_W   = 5,
  localparam int TW = $clog2(N_THR),
  localparam int NW = $clog2(PER_MAX + 1)
) (
  input  logic [N_THR*CNT_W-1:0] key_i,
  input  logic [N_THR-1:0]       elig_i,
  input  logic [TW-1:0]          ptr_i,
  output logic [SLOTS-1:0]       vld_o,
  output logic [SLOTS*TW-1:0]    tid_o,
  output logic [SLOTS*NW-1:0]    num_o
);
  logic [N_THR-1:0] taken;
  logic [CNT_W-1:0] best_k;
  logic             found;
  int               best_t, best_d, d, rem, n;

  // Greedy pass per slot: lowest {key, distance from pointer} among untaken candidates
  always_comb begin
    taken  = '0;
    vld_o  = '0;
    tid_o  = '0;
    num_o  = '0;
    rem    = FETCH_W;
    best_k = '0;
    found  = 1'b0;
    best_t = 0;
    best_d = 0;
    d      = 0;
    n      = 0;
    for (int s = 0; s < SLOTS; s++) begin
      found  = 1'b0;
      best_t = 0;
      best_d = 0;
      best_k = '0;
      for (int t = 0; t < N_THR; t++) begin
        d = (t >= int'(ptr_i)) ? t - int'(ptr_i) : t + N_THR - int'(ptr_i);
        if (elig_i[t] && !taken[t]) begin
          if (!found || key_i[t*CNT_W +: CNT_W] < best_k ||
              (key_i[t*CNT_W +: CNT_W] == best_k && d < best_d)) begin
            found  = 1'b1;
            best_t = t;
            best_d = d;
            best_k = key_i[t*CNT_W +: CNT_W];
          end
        end
      end
      if (found && rem > 0) begin
        n = (rem < PER_MAX) ? rem : PER_MAX;
        vld_o[s]            = 1'b1;
        tid_o[s*TW +: TW]   = TW'(best_t);
        num_o[s*NW +: NW]   = NW'(n);
        taken[best_t]       = 1'b1;
        rem                 = rem - n;
      end
    end
  end
endmodule

// File: rtl/fetch_sel_top.sv
module fetch_sel_top #(
  parameter int N_THR   = 8,
  parameter int SLOTS   = 2,
  parameter int PER_MAX = 4,
  parameter int FETCH_W = 8,
  parameter int CNT_W   = 5,
  localparam int TW = $clog2(N_THR),
  localparam int NW = $clog2(PER_MAX + 1),
  localparam int EW = $clog2(FETCH_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          policy_i,
  input  logic [N_THR-1:0]    ready_i,
  input  logic [N_THR-1:0]    stall_i,
  input  logic [N_THR*EW-1:0] fetch_num_i,
  input  logic [N_THR*EW-1:0] issue_num_i,
  input  logic [N_THR-1:0]    br_inc_i,
  input  logic [N_THR-1:0]    br_dec_i,
  input  logic [N_THR-1:0]    miss_inc_i,
  input  logic [N_THR-1:0]    miss_dec_i,
  output logic [SLOTS-1:0]    slot_vld_o,
  output logic [SLOTS*TW-1:0] slot_tid_o,
  output logic [SLOTS*NW-1:0] slot_num_o
);
  import fetch_sel_pkg::*;

  logic [CNT_W-1:0]       icnt [N_THR];
  logic [CNT_W-1:0]       bcnt [N_THR];
  logic [CNT_W-1:0]       mcnt [N_THR];
  logic [N_THR*CNT_W-1:0] key;
  logic [TW-1:0]          ptr_q;
  logic [SLOTS-1:0]       vld_d;
  logic [SLOTS*TW-1:0]    tid_d;
  logic [SLOTS*NW-1:0]    num_d;
  fetch_pol_e             pol;

  assign pol = fetch_pol_e'(policy_i);

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    fetch_sat_cnt #(.CNT_W(CNT_W), .STEP_W(EW)) u_icnt (
      .clk_i, .rst_ni,
      .inc_i(fetch_num_i[t*EW +: EW]),
      .dec_i(issue_num_i[t*EW +: EW]),
      .cnt_o(icnt[t])
    );
    fetch_sat_cnt #(.CNT_W(CNT_W), .STEP_W(1)) u_bcnt (
      .clk_i, .rst_ni, .inc_i(br_inc_i[t]), .dec_i(br_dec_i[t]), .cnt_o(bcnt[t])
    );
    fetch_sat_cnt #(.CNT_W(CNT_W), .STEP_W(1)) u_mcnt (
      .clk_i, .rst_ni, .inc_i(miss_inc_i[t]), .dec_i(miss_dec_i[t]), .cnt_o(mcnt[t])
    );

    always_comb begin
      unique case (pol)
        POL_ICNT: key[t*CNT_W +: CNT_W] = icnt[t];
        POL_BR:   key[t*CNT_W +: CNT_W] = bcnt[t];
        POL_MISS: key[t*CNT_W +: CNT_W] = mcnt[t];
        default:  key[t*CNT_W +: CNT_W] = '0;  // round-robin: pointer alone decides
      endcase
    end
  end

  fetch_ranker #(
    .N_THR(N_THR), .SLOTS(SLOTS), .PER_MAX(PER_MAX),
    .FETCH_W(FETCH_W), .CNT_W(CNT_W)
  ) u_rank (
    .key_i (key),
    .elig_i(ready_i & ~stall_i),
    .ptr_i (ptr_q),
    .vld_o (vld_d),
    .tid_o (tid_d),
    .num_o (num_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      slot_vld_o <= '0;
      slot_tid_o <= '0;
      slot_num_o <= '0;
    end else begin
      ptr_q      <= (int'(ptr_q) == N_THR - 1) ? '0 : ptr_q + 1'b1;
      slot_vld_o <= vld_d;
      slot_tid_o <= tid_d;
      slot_num_o <= num_d;
    end
  end
endmodule

// File: rtl/fetch_sel_chk.sv
module fetch_sel_chk #(
  parameter int N_THR   = 8,
  parameter int SLOTS   = 2,
  parameter int PER_MAX = 4,
  parameter int FETCH_W = 8,
  localparam int TW = $clog2(N_THR),
  localparam int NW = $clog2(PER_MAX + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_THR-1:0]    ready_i,
  input logic [N_THR-1:0]    stall_i,
  input logic [SLOTS-1:0]    slot_vld_o,
  input logic [SLOTS*TW-1:0] slot_tid_o,
  input logic [SLOTS*NW-1:0] slot_num_o
);
  logic [N_THR-1:0] elig_q;
  logic             dup;
  int               tot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_q <= '0;
    else         elig_q <= ready_i & ~stall_i;
  end

  always_comb begin
    dup = 1'b0;
    tot = 0;
    for (int a = 0; a < SLOTS; a++) begin
      tot = tot + int'(slot_num_o[a*NW +: NW]);
      for (int b = a + 1; b < SLOTS; b++)
        if (slot_vld_o[a] && slot_vld_o[b] && slot_tid_o[a*TW +: TW] == slot_tid_o[b*TW +: TW])
          dup = 1'b1;
    end
  end

  assert_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni) tot <= FETCH_W);
  assert_distinct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assert_elig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[s] |-> elig_q[slot_tid_o[s*TW +: TW]]);
    assert_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[s] |-> (slot_num_o[s*NW +: NW] != '0 && int'(slot_num_o[s*NW +: NW]) <= PER_MAX));
    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_vld_o[s] |-> (slot_num_o[s*NW +: NW] == '0 && slot_tid_o[s*TW +: TW] == '0));
    if (s > 0) begin : g_ord
      assert_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s] |-> slot_vld_o[s-1]);
    end
  end
endmodule

bind fetch_sel_top fetch_sel_chk #(
  .N_THR(N_THR), .SLOTS(SLOTS), .PER_MAX(PER_MAX), .FETCH_W(FETCH_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .stall_i(stall_i),
  .slot_vld_o(slot_vld_o), .slot_tid_o(slot_tid_o), .slot_num_o(slot_num_o)
);

// File: tb/test_fetch_sel_top.sv
`timescale 1ns/1ps
module test_fetch_sel_top;
  localparam int N = 8, S = 3, PMAX = 4, FW = 10, CW = 4;
  localparam int TW = $clog2(N), NW = $clog2(PMAX + 1), EW = $clog2(FW + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = '0;
  logic [N-1:0] ready = '0, stall = '0, bri = '0, brd = '0, mi = '0, md = '0;
  logic [N*EW-1:0] fnum = '0, inum = '0;
  logic [S-1:0] vld;
  logic [S*TW-1:0] tid;
  logic [S*NW-1:0] num;

  always #2.5 clk = ~clk;

  fetch_sel_top #(.N_THR(N), .SLOTS(S), .PER_MAX(PMAX), .FETCH_W(FW), .CNT_W(CW)) i_fetch_sel_top (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .ready_i(ready), .stall_i(stall),
    .fetch_num_i(fnum), .issue_num_i(inum), .br_inc_i(bri), .br_dec_i(brd),
    .miss_inc_i(mi), .miss_dec_i(md), .slot_vld_o(vld), .slot_tid_o(tid), .slot_num_o(num));

  int checks = 0, failures = 0;
  bit done = 0;
  int m_i[N], m_b[N], m_m[N], m_ptr;
  int e_v[S], e_t[S], e_n[S];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > CMAX) return CMAX;
    return v;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin m_i[t] = 0; m_b[t] = 0; m_m[t] = 0; end
    m_ptr = 0;
    for (int s = 0; s < S; s++) begin e_v[s] = 0; e_t[s] = 0; e_n[s] = 0; end
  endtask

  task automatic model_step();
    int key[N];
    bit used[N];
    int rem = FW;
    for (int t = 0; t < N; t++) begin
      used[t] = 0;
      case (policy)
        2'd1: key[t] = m_i[t];
        2'd2: key[t] = m_b[t];
        2'd3: key[t] = m_m[t];
        default: key[t] = 0;
      endcase
    end
    for (int s = 0; s < S; s++) begin
      int bt = -1, bk = 0, bd = 0;
      for (int t = 0; t < N; t++) begin
        int dd = (t - m_ptr + N) % N;
        if (ready[t] && !stall[t] && !used[t] &&
            (bt < 0 || key[t] < bk || (key[t] == bk && dd < bd))) begin
          bt = t; bk = key[t]; bd = dd;
        end
      end
      if (bt >= 0 && rem > 0) begin
        e_v[s] = 1; e_t[s] = bt; e_n[s] = (rem < PMAX) ? rem : PMAX;
        used[bt] = 1; rem -= e_n[s];
      end else begin
        e_v[s] = 0; e_t[s] = 0; e_n[s] = 0;
      end
    end
    for (int t = 0; t < N; t++) begin
      m_i[t] = clampc(m_i[t] + int'(fnum[t*EW +: EW]) - int'(inum[t*EW +: EW]));
      m_b[t] = clampc(m_b[t] + int'(bri[t]) - int'(brd[t]));
      m_m[t] = clampc(m_m[t] + int'(mi[t]) - int'(md[t]));
    end
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic compare(string req);
    for (int s = 0; s < S; s++) begin
      check(req, $sformatf("slot%0d valid", s), int'(vld[s]), e_v[s]);
      check(req, $sformatf("slot%0d tid", s), int'(tid[s*TW +: TW]), e_t[s]);
      check(req, $sformatf("slot%0d num", s), int'(num[s*NW +: NW]), e_n[s]);
    end
  endtask

  // style: 0 idle all ready, 1 random, 2 fetch burst, 3 issue burst, 4 branch/miss traffic
  task automatic drive(int style);
    for (int t = 0; t < N; t++) begin
      int f = 0, i = 0;
      case (style)
        0: begin ready[t] = 1; stall[t] = 0; end
        1: begin ready[t] = ($urandom_range(0, 3) != 0); stall[t] = ($urandom_range(0, 4) == 0);
                 f = $urandom_range(0, 4); i = $urandom_range(0, 4); end
        2: begin ready[t] = 1; stall[t] = 0; f = (t % 2 == 0) ? FW : 0; end
        3: begin ready[t] = 1; stall[t] = 0; i = FW; end
        default: begin ready[t] = ($urandom_range(0, 4) != 0); stall[t] = 0;
                 f = $urandom_range(0, 2); i = $urandom_range(0, 2); end
      endcase
      fnum[t*EW +: EW] = EW'(f);
      inum[t*EW +: EW] = EW'(i);
      bri[t] = (style == 4) && ($urandom_range(0, 2) == 0);
      brd[t] = (style == 4) && ($urandom_range(0, 2) == 0);
      mi[t]  = (style == 4) && ($urandom_range(0, 2) == 0);
      md[t]  = (style == 4) && ($urandom_range(0, 3) == 0);
    end
  endtask

  task automatic run(int pol, int style, int cycles, string req);
    policy = 2'(pol);
    for (int c = 0; c < cycles; c++) begin
      drive(style);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(1ms);
    failures++;
    $display("FAIL watchdog expired expected completion");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    run(0, 0, 12, "R5");
    run(0, 1, 30, "R2");
    run(1, 1, 60, "R3");
    run(1, 2, 6, "R4");
    run(1, 3, 3, "R4");
    run(1, 1, 20, "R4");
    run(1, 3, 4, "R6");
    run(1, 0, 10, "R6");
    run(2, 4, 40, "R7");
    run(3, 4, 40, "R8");

    // width split: 4 + 4 + 2 with all threads eligible
    run(0, 0, 1, "R9");
    check("R9", "slot2 count under width limit", int'(num[2*NW +: NW]), FW - 2 * PMAX);
    check("R9", "total granted", int'(num[0 +: NW]) + int'(num[NW +: NW]) + int'(num[2*NW +: NW]), FW);

    // registered latency: stall every thread, outputs hold until next edge
    stall = '1;
    #1;
    check("R10", "slot0 valid before edge", int'(vld[0]), 1);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R10", "slot0 valid after edge", int'(vld[0]), 0);
    compare("R10");

    // mid-run reset clears counters and pointer
    run(1, 2, 3, "R3");
    rst_n = 1'b0;
    #1;
    model_reset();
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    run(1, 0, 9, "R1");
    run(1, 1, 30, "R3");
    finish_up();
  end
endmodule